// File: doc/BRIEF.md
# Analog Input Channel Sequencer

This block turns a converter control byte into the selects for a four-input analog multiplexer. The byte picks one of four ways of pairing the inputs into channels (all single-ended, three inputs against a common fourth, a mixed set, or two differential pairs). It also picks a channel within that pairing. For the working channel the block drives a positive-input select, a negative-input select and a flag that marks the measurement as differential. A separate bit in the same byte drives the enable for the analog output and its oscillator.

The converter marks each conversion with a start pulse and a done pulse. The sequencer holds its mux selects steady for the whole of every conversion. When auto-increment is on, it moves to the next channel once a conversion completes, and wraps to channel 0 after the last channel the active pairing offers. A channel number beyond what the pairing offers is replaced by the highest channel that does exist. A control byte that arrives while a conversion is running is held back and applied when that conversion completes.

Top module: `ain_seq`

## Requirements
- R1: The control byte is decoded as bit 6 = output/oscillator enable, bits 5:4 = pairing mode, bit 2 = auto-increment, bits 1:0 = requested channel. Bits 7 and 3 have no effect on any output.
- R2: After reset the outputs read chan=0, pos_sel=0, neg_sel=0, diff_sel=0 and aout_en=0, and auto-increment is off.
- R3: The highest channel is 3 in mode 0, 2 in modes 1 and 2, and 1 in mode 3. A requested channel above that limit becomes the limit.
- R4: Routing for channel c. Mode 0: pos=c, single-ended. Mode 1: pos=c, neg=3, differential. Mode 2: channels 0 and 1 give pos=c single-ended, and channel 2 gives pos=2, neg=3, differential. Mode 3: pos=2c, neg=2c+1, differential.
- R5: Whenever diff_sel is 0, neg_sel reads 0.
- R6: With auto-increment on, each completed conversion moves chan to chan+1. From the highest channel of the mode it moves to 0.
- R7: With auto-increment off, completed conversions leave chan unchanged.
- R8: From the clock edge that takes conv_start while idle until the edge that takes conv_done, pos_sel, neg_sel, diff_sel and chan do not change.
- R9: A load taken during a conversion changes mode, channel and auto-increment only at the edge that takes conv_done, and it replaces the increment. Its enable bit drives aout_en one edge after the load.
- R10: conv_done while no conversion is running has no effect.
- R11: A load while idle shows on all outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_byte | input | 8 | Control byte |
| ctrl_load | input | 1 | Strobe that takes ctrl_byte |
| conv_start | input | 1 | A conversion begins |
| conv_done | input | 1 | The running conversion completes |
| pos_sel | output | 2 | Positive analog input index |
| neg_sel | output | 2 | Negative analog input index (0 when single-ended) |
| diff_sel | output | 1 | Working channel is differential |
| chan | output | 2 | Working channel number |
| aout_en | output | 1 | Analog output and oscillator enable |

## Verification
The hardest case to reach is a control byte that arrives in the middle of a conversion. The bench has to confirm that the selects stay frozen and the enable changes at once, and that the deferred byte then wins over the auto-increment at the done edge. The bench opens a conversion with a start pulse and loads a byte mid-conversion. It samples the outputs both before and after the done pulse, with auto-increment set in the old byte so that a wrong precedence shows up as an incremented channel. A sweep over all 256 control bytes covers the clamping and routing of every mode. Each auto-increment byte is then carried through five conversions, so the wrap point of every mode is crossed.

// File: rtl/ain_seq_pkg.sv
package ain_seq_pkg;
    localparam int CTRL_W   = 8;
    localparam int CH_W     = 2;
    localparam int SEL_W    = 2;
    localparam int BIT_AOUT = 6;
    localparam int MODE_LSB = 4;
    localparam int BIT_AUTO = 2;

    typedef enum logic [1:0] {
        MODE_SE4   = 2'd0,
        MODE_DIFF3 = 2'd1,
        MODE_MIX   = 2'd2,
        MODE_DIFF2 = 2'd3
    } mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] pos;
        logic [SEL_W-1:0] neg;
        logic             diff;
    } route_t;

    typedef struct packed {
        mode_e           mode;
        logic [CH_W-1:0] chan;
        logic            autoinc;
        logic            aout;
        logic            busy;
        logic            pend;
        mode_e           p_mode;
        logic [CH_W-1:0] p_chan;
        logic            p_auto;
        route_t          rt;
    } seq_state_t;

    function automatic logic [CH_W-1:0] max_chan(input mode_e m);
        case (m)
            MODE_SE4:   max_chan = CH_W'(3);
            MODE_DIFF3: max_chan = CH_W'(2);
            MODE_MIX:   max_chan = CH_W'(2);
            default:    max_chan = CH_W'(1);
        endcase
    endfunction

    function automatic route_t route(input mode_e m, input logic [CH_W-1:0] c);
        route_t r;
        r = '0;
        case (m)
            MODE_SE4: r.pos = SEL_W'(c);
            MODE_DIFF3: begin
                r.pos  = SEL_W'(c);
                r.neg  = SEL_W'(3);
                r.diff = 1'b1;
            end
            MODE_MIX: begin
                r.pos = SEL_W'(c);
                if (c == CH_W'(2)) begin
                    r.neg  = SEL_W'(3);
                    r.diff = 1'b1;
                end
            end
            default: begin
                r.pos  = SEL_W'({c[0], 1'b0});
                r.neg  = SEL_W'({c[0], 1'b1});
                r.diff = 1'b1;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ain_seq_clamp.sv
module ain_seq_clamp
    import ain_seq_pkg::*;
(
    input  mode_e           mode,
    input  logic [CH_W-1:0] req,
    output logic [CH_W-1:0] chan
);
    logic [CH_W-1:0] limit;

    always_comb begin
        limit = max_chan(mode);
        chan  = (req > limit) ? limit : req;
    end
endmodule

// File: rtl/ain_seq_step.sv
module ain_seq_step
    import ain_seq_pkg::*;
(
    input  mode_e           mode,
    input  logic [CH_W-1:0] chan,
    output logic [CH_W-1:0] nxt
);
    always_comb begin
        if (chan >= max_chan(mode)) nxt = '0;
        else                        nxt = chan + CH_W'(1);
    end
endmodule

// File: rtl/ain_seq.sv
module ain_seq
    import ain_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_byte,
    input  logic              ctrl_load,
    input  logic              conv_start,
    input  logic              conv_done,
    output logic [SEL_W-1:0]  pos_sel,
    output logic [SEL_W-1:0]  neg_sel,
    output logic              diff_sel,
    output logic [CH_W-1:0]   chan,
    output logic              aout_en
);
    seq_state_t st_d, st_q;

    mode_e           ld_mode;
    logic            ld_auto;
    logic [CH_W-1:0] ld_chan;
    logic [CH_W-1:0] step_chan;
    logic            unused_reserved;

    // Field extraction; reserved bits 7 and 3 are dropped (R1)
    assign ld_mode         = mode_e'(ctrl_byte[MODE_LSB+1:MODE_LSB]);
    assign ld_auto         = ctrl_byte[BIT_AUTO];
    assign unused_reserved = ctrl_byte[7] ^ ctrl_byte[3];

    ain_seq_clamp u_clamp (
        .mode (ld_mode),
        .req  (ctrl_byte[CH_W-1:0]),
        .chan (ld_chan)
    );

    ain_seq_step u_step (
        .mode (st_q.mode),
        .chan (st_q.chan),
        .nxt  (step_chan)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_load) st_d.aout = ctrl_byte[BIT_AOUT];
        if (!st_q.busy) begin
            if (ctrl_load) begin
                st_d.mode    = ld_mode;
                st_d.chan    = ld_chan;
                st_d.autoinc = ld_auto;
            end
            if (conv_start) st_d.busy = 1'b1;
        end else if (conv_done) begin
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
            if (ctrl_load) begin
                st_d.mode    = ld_mode;
                st_d.chan    = ld_chan;
                st_d.autoinc = ld_auto;
            end else if (st_q.pend) begin
                st_d.mode    = st_q.p_mode;
                st_d.chan    = st_q.p_chan;
                st_d.autoinc = st_q.p_auto;
            end else if (st_q.autoinc) begin
                st_d.chan = step_chan;
            end
        end else if (ctrl_load) begin
            st_d.pend   = 1'b1;
            st_d.p_mode = ld_mode;
            st_d.p_chan = ld_chan;
            st_d.p_auto = ld_auto;
        end
        st_d.rt = route(st_d.mode, st_d.chan);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_sel  = st_q.rt.pos;
    assign neg_sel  = st_q.rt.neg;
    assign diff_sel = st_q.rt.diff;
    assign chan     = st_q.chan;
    assign aout_en  = st_q.aout;

    logic       busy_w;
    logic       pend_w;
    logic       auto_w;
    logic [1:0] mode_w;
    assign busy_w = st_q.busy;
    assign pend_w = st_q.pend;
    assign auto_w = st_q.autoinc;
    assign mode_w = st_q.mode;
endmodule

// File: rtl/ain_seq_chk.sv
module ain_seq_chk
    import ain_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_load,
    input logic             conv_done,
    input logic [SEL_W-1:0] pos_sel,
    input logic [SEL_W-1:0] neg_sel,
    input logic             diff_sel,
    input logic [CH_W-1:0]  chan,
    input logic             aout_en,
    input logic             busy,
    input logic             pend,
    input logic             autoinc,
    input logic [1:0]       mode
);
    a_r2_enable_off_in_reset: assert property (@(posedge clk)
        !rst_n |=> !aout_en);

    a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        chan <= max_chan(mode_e'(mode)));

    a_r4_pairs_differential: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (diff_sel && neg_sel == pos_sel + SEL_W'(1)));

    a_r5_neg_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
        !diff_sel |-> (neg_sel == '0));

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && !ctrl_load && !pend && autoinc
         && chan == max_chan(mode_e'(mode))) |=> (chan == '0));

    a_r8_hold_during_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> ($stable(pos_sel) && $stable(neg_sel)
                                  && $stable(diff_sel) && $stable(chan)));

    a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl_load) |=> $stable(chan));
endmodule

bind ain_seq ain_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_load (ctrl_load),
    .conv_done (conv_done),
    .pos_sel   (pos_sel),
    .neg_sel   (neg_sel),
    .diff_sel  (diff_sel),
    .chan      (chan),
    .aout_en   (aout_en),
    .busy      (busy_w),
    .pend      (pend_w),
    .autoinc   (auto_w),
    .mode      (mode_w)
);

// File: tb/ain_seq_test.sv
module ain_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl_byte = '0;
    logic       ctrl_load = 1'b0;
    logic       conv_start = 1'b0;
    logic       conv_done = 1'b0;
    logic [1:0] pos_sel, neg_sel, chan;
    logic       diff_sel, aout_en;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    // expected model state
    int e_mode, e_chan, e_auto, e_aout;

    always #5 clk = ~clk;

    ain_seq uut (
        .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .ctrl_load(ctrl_load),
        .conv_start(conv_start), .conv_done(conv_done), .pos_sel(pos_sel),
        .neg_sel(neg_sel), .diff_sel(diff_sel), .chan(chan), .aout_en(aout_en)
    );

    function automatic int lim(int m);
        return (m == 0) ? 3 : (m == 3) ? 1 : 2;
    endfunction

    function automatic int xpos(int m, int c);
        return (m == 3) ? 2 * c : c;
    endfunction

    function automatic int xdiff(int m, int c);
        return (m == 0) ? 0 : (m == 2) ? ((c == 2) ? 1 : 0) : 1;
    endfunction

    function automatic int xneg(int m, int c);
        if (xdiff(m, c) == 0) return 0;
        return (m == 3) ? 2 * c + 1 : 3;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " chan"}, chan, e_chan);
        chk({req, " pos"}, pos_sel, xpos(e_mode, e_chan));
        chk({req, " neg"}, neg_sel, xneg(e_mode, e_chan));
        chk({req, " diff"}, diff_sel, xdiff(e_mode, e_chan));
        chk({req, " aout"}, aout_en, e_aout);
    endtask

    task automatic model_load(logic [7:0] b);
        e_mode = int'(b[5:4]);
        e_auto = int'(b[2]);
        e_aout = int'(b[6]);
        e_chan = (int'(b[1:0]) > lim(e_mode)) ? lim(e_mode) : int'(b[1:0]);
    endtask

    task automatic load(logic [7:0] b);
        @(negedge clk);
        ctrl_byte = b;
        ctrl_load = 1'b1;
        @(negedge clk);
        ctrl_load = 1'b0;
    endtask

    task automatic start_conv();
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    task automatic finish_conv();
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        e_mode = 0; e_chan = 0; e_auto = 0; e_aout = 0;
        chk_all("R2");

        // Sweep every control byte: R1 R3 R4 R5 R11, then R6/R7/R8
        for (int b = 0; b < 256; b++) begin
            load(8'(b));
            model_load(8'(b));
            chk_all((b[7] | b[3]) ? "R1_reserved" : "R11_R3_R4_R5");
            for (int k = 0; k < ((e_auto != 0) ? 5 : 2); k++) begin
                start_conv();
                @(negedge clk);
                chk_all("R8");
                finish_conv();
                if (e_auto != 0)
                    e_chan = (e_chan >= lim(e_mode)) ? 0 : e_chan + 1;
                chk_all((e_auto != 0) ? "R6" : "R7");
            end
        end

        // R10: done pulse while idle, auto-increment on
        load(8'h14);
        model_load(8'h14);
        finish_conv();
        chk_all("R10");

        // R9: load during conversion deferred, overrides increment
        load(8'h05);
        model_load(8'h05);
        start_conv();
        load(8'h73);
        chk("R9 aout immediate", aout_en, 1);
        chk("R9 chan held", chan, 1);
        chk("R9 diff held", diff_sel, 0);
        finish_conv();
        model_load(8'h73);
        chk_all("R9 applied");

        // R9: load in the same cycle as done applies, no increment
        load(8'h06);
        model_load(8'h06);
        start_conv();
        @(negedge clk);
        ctrl_byte = 8'h21;
        ctrl_load = 1'b1;
        conv_done = 1'b1;
        @(negedge clk);
        ctrl_load = 1'b0;
        conv_done = 1'b0;
        model_load(8'h21);
        chk_all("R9 same edge");

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule